// File: doc/BRIEF.md
# Command and Receive FIFO Pair with Level Interrupts

This block sits between a host register interface and a serial bus engine. It holds two independent first-in first-out queues. The command queue carries 11-bit command words that the host pushes and the engine pops. The receive queue carries 8-bit data bytes that the engine pushes and the host pops. Both queues are show-ahead: the oldest entry is always visible on the read-data port, and a pop discards it.

A 14-bit control word holds a level-held clear for each queue and two 6-bit level thresholds. From the two occupancy counts the block derives a 12-bit status vector and three raw interrupt conditions: receive level high, command level low, and any queue error. A push into a full queue or a pop from an empty queue is refused. It also sets a sticky error flag, which stays set until that queue is cleared. Masking and acknowledging the interrupts are left to the surrounding logic.

Each queue tracks its occupancy class with a three-state machine. `QS_EMPTY` moves to `QS_PART` on T_FILL (an accepted push), or straight to `QS_FULL` when the depth is one. `QS_PART` moves to `QS_EMPTY` on T_DRAIN (the count reaches 0) and to `QS_FULL` on T_TOP (the count reaches the depth). `QS_FULL` moves back to `QS_PART` on T_LEAVE (an accepted pop with no accepted push). Any state moves to `QS_EMPTY` on T_CLEAR while its clear bit is 1.

Top module: `qp_fifo_pair`

## Requirements
- R1: Each queue holds 64 entries and returns them in push order. The read-data port shows the oldest entry without a pop. The command queue is 11 bits wide and the receive queue 8 bits wide.
- R2: A push and a pop on the same clock edge to a queue that is neither empty nor full both take effect, and the occupancy is unchanged.
- R3: Control bit 0 clears the receive queue and control bit 1 clears the command queue. While the bit is 1 the queue stays empty, its pushes and pops are ignored without raising errors, and its error flags are cleared. Normal operation resumes once the bit returns to 0.
- R4: Status bit 3 is 1 when the receive occupancy is 0. Status bit 11 is 1 when the command occupancy is 64. Status bits 2, 4, 5, 8, 9 and 10 read 0.
- R5: A push to a queue holding 64 entries is dropped, and the contents are unchanged. It sets the write-error flag: status bit 7 for the command queue, status bit 1 for the receive queue. A pop on the same edge still takes effect.
- R6: A pop from an empty queue is ignored. It sets the read-error flag: status bit 6 for the command queue, status bit 0 for the receive queue. A push on the same edge still takes effect.
- R7: An error flag stays set until the clear bit of its queue is 1.
- R8: `irq_rx_full` is 1 exactly while the receive occupancy is at or above control bits [7:2].
- R9: `irq_tx_empty` is 1 exactly while the command occupancy is at or below control bits [13:8].
- R10: `irq_fifo_err` is 1 exactly while any of the four error flags is set.
- R11: After reset both queues are empty with all flags clear, so the status reads 12'h008. Every output reflects a push, pop or clear from the clock edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 14 | Clears in bits 1:0, receive threshold in bits [7:2], command threshold in bits [13:8] |
| host_cmd_push | input | 1 | Push `host_cmd_data` into the command queue |
| host_cmd_data | input | 11 | Command word to push |
| eng_cmd_pop | input | 1 | Pop the oldest command |
| eng_cmd_data | output | 11 | Oldest command word |
| eng_rx_push | input | 1 | Push `eng_rx_data` into the receive queue |
| eng_rx_data | input | 8 | Received byte to push |
| host_rx_pop | input | 1 | Pop the oldest received byte |
| host_rx_data | output | 8 | Oldest received byte |
| fifo_status | output | 12 | Error, empty and full flags |
| irq_rx_full | output | 1 | Receive occupancy at or above its threshold |
| irq_tx_empty | output | 1 | Command occupancy at or below its threshold |
| irq_fifo_err | output | 1 | Any error flag set |

## Verification
The assertions expect reset to be applied from time zero. They do not assume that pushes and pops respect the full and empty flags. Overflow, underflow and same-edge push and pop are all legal inputs whose outcomes are defined. The stimulus drives every input only between clock edges. It drives the queues deliberately past both limits, and it toggles the clear bits and thresholds at random, so that each clear bit is exercised both with and without traffic on its queue.

// File: rtl/qp_pkg.sv
package qp_pkg;
    // Status vector layout (decoded by the register decoder)
    localparam int ST_W        = 12;
    localparam int ST_RX_RERR  = 0;
    localparam int ST_RX_WERR  = 1;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_TX_RERR  = 6;
    localparam int ST_TX_WERR  = 7;
    localparam int ST_TX_FULL  = 11;

    // Control word clear bits
    localparam int CTL_RX_CLR  = 0;
    localparam int CTL_TX_CLR  = 1;
    localparam int CTL_THR_LSB = 2;

    typedef enum logic [1:0] {
        QS_EMPTY = 2'd0,
        QS_PART  = 2'd1,
        QS_FULL  = 2'd2
    } qstate_t;
endpackage

// File: rtl/qp_queue.sv
module qp_queue
    import qp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             rd_err,
    output logic             wr_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt, cnt_nx;
    qstate_t          st, st_nx;
    logic             push_ok, pop_ok;

    // Acceptance decided from the occupancy count before the edge
    assign push_ok = push && !clr && (cnt != CNT_MAX);
    assign pop_ok  = pop  && !clr && (cnt != '0);

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   cnt_nx = cnt + 1'b1;
            2'b01:   cnt_nx = cnt - 1'b1;
            default: cnt_nx = cnt;
        endcase
        if (clr) cnt_nx = '0;
    end

    // Next-state logic for the occupancy class
    always_comb begin
        st_nx = st;
        unique case (st)
            QS_EMPTY: if (push_ok) st_nx = (cnt_nx == CNT_MAX) ? QS_FULL : QS_PART;   // T_FILL
            QS_PART: begin
                if (cnt_nx == '0)          st_nx = QS_EMPTY;                           // T_DRAIN
                else if (cnt_nx == CNT_MAX) st_nx = QS_FULL;                           // T_TOP
            end
            QS_FULL:  if (pop_ok && !push_ok) st_nx = (cnt_nx == '0) ? QS_EMPTY : QS_PART; // T_LEAVE
            default:  st_nx = QS_EMPTY;
        endcase
        if (clr) st_nx = QS_EMPTY;                                                     // T_CLEAR
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= QS_EMPTY;
        else        st <= st_nx;
    end

    // Pointers, count and sticky errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            rd_err <= 1'b0;
            wr_err <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            rd_err <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (pop && (cnt == '0))       rd_err <= 1'b1;
            if (push && (cnt == CNT_MAX)) wr_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Output process
    always_comb begin
        pop_data = mem[rd_ptr];
        count    = cnt;
        is_empty = (st == QS_EMPTY);
        is_full  = (st == QS_FULL);
    end
endmodule

// File: rtl/qp_flags.sv
module qp_flags
    import qp_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int THR_W = 6
) (
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic             rx_empty,
    input  logic             rx_rd_err,
    input  logic             rx_wr_err,
    input  logic             tx_full,
    input  logic             tx_rd_err,
    input  logic             tx_wr_err,
    output logic [ST_W-1:0]  status,
    output logic             irq_rx_full,
    output logic             irq_tx_empty,
    output logic             irq_fifo_err
);
    always_comb begin
        status              = '0;
        status[ST_RX_RERR]  = rx_rd_err;
        status[ST_RX_WERR]  = rx_wr_err;
        status[ST_RX_EMPTY] = rx_empty;
        status[ST_TX_RERR]  = tx_rd_err;
        status[ST_TX_WERR]  = tx_wr_err;
        status[ST_TX_FULL]  = tx_full;
        irq_rx_full  = (int'(rx_cnt) >= int'(rx_thr));
        irq_tx_empty = (int'(tx_cnt) <= int'(tx_thr));
        irq_fifo_err = rx_rd_err | rx_wr_err | tx_rd_err | tx_wr_err;
    end
endmodule

// File: rtl/qp_fifo_pair.sv
module qp_fifo_pair
    import qp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CMD_W = 11,
    parameter int RX_W  = 8,
    parameter int THR_W = 6,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CTRL_W = CTL_THR_LSB + 2 * THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              host_cmd_push,
    input  logic [CMD_W-1:0]  host_cmd_data,
    input  logic              eng_cmd_pop,
    output logic [CMD_W-1:0]  eng_cmd_data,
    input  logic              eng_rx_push,
    input  logic [RX_W-1:0]   eng_rx_data,
    input  logic              host_rx_pop,
    output logic [RX_W-1:0]   host_rx_data,
    output logic [ST_W-1:0]   fifo_status,
    output logic              irq_rx_full,
    output logic              irq_tx_empty,
    output logic              irq_fifo_err
);
    localparam int RX_THR_LSB = CTL_THR_LSB;
    localparam int TX_THR_LSB = CTL_THR_LSB + THR_W;

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_empty, tx_full, tx_rerr, tx_werr;
    logic rx_empty, rx_full, rx_rerr, rx_werr;

    qp_queue #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .clr(ctrl_word[CTL_TX_CLR]),
        .push(host_cmd_push), .push_data(host_cmd_data),
        .pop(eng_cmd_pop), .pop_data(eng_cmd_data),
        .count(tx_cnt), .is_empty(tx_empty), .is_full(tx_full),
        .rd_err(tx_rerr), .wr_err(tx_werr)
    );

    qp_queue #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clr(ctrl_word[CTL_RX_CLR]),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(host_rx_pop), .pop_data(host_rx_data),
        .count(rx_cnt), .is_empty(rx_empty), .is_full(rx_full),
        .rd_err(rx_rerr), .wr_err(rx_werr)
    );

    qp_flags #(.CNT_W(CNT_W), .THR_W(THR_W)) u_flags (
        .rx_thr(ctrl_word[RX_THR_LSB +: THR_W]),
        .tx_thr(ctrl_word[TX_THR_LSB +: THR_W]),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .rx_empty(rx_empty), .rx_rd_err(rx_rerr), .rx_wr_err(rx_werr),
        .tx_full(tx_full), .tx_rd_err(tx_rerr), .tx_wr_err(tx_werr),
        .status(fifo_status), .irq_rx_full(irq_rx_full),
        .irq_tx_empty(irq_tx_empty), .irq_fifo_err(irq_fifo_err)
    );
endmodule

// File: rtl/qp_fifo_pair_chk.sv
module qp_fifo_pair_chk
    import qp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 7,
    parameter int CTRL_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              host_cmd_push,
    input logic              eng_cmd_pop,
    input logic              eng_rx_push,
    input logic              host_rx_pop,
    input logic [ST_W-1:0]   fifo_status,
    input logic              irq_fifo_err,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              tx_empty,
    input logic              rx_full
);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

    // R1: occupancy never exceeds the depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CMAX) && (rx_cnt <= CMAX));

    // R2: occupancy moves by at most one entry per edge, unless cleared
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_word[CTL_TX_CLR]) |->
        ((int'(tx_cnt) - int'($past(tx_cnt)) <= 1) && (int'($past(tx_cnt)) - int'(tx_cnt) <= 1)));

    // R3: a held clear empties the command queue and drops its flags
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[CTL_TX_CLR] |=> (tx_cnt == '0) && tx_empty
            && !fifo_status[ST_TX_RERR] && !fifo_status[ST_TX_WERR]);

    // R4: the full flag from the state machine agrees with the count
    a_r4_full_matches: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[ST_TX_FULL] == (tx_cnt == CMAX));

    // R4: receive full state agrees with its count
    a_r4_rx_full_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full == (rx_cnt == CMAX));

    // R5: push at full without a pop keeps the queue full and flags it
    a_r5_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CMAX) && host_cmd_push && !eng_cmd_pop && !ctrl_word[CTL_TX_CLR]
        |=> (tx_cnt == CMAX) && fifo_status[ST_TX_WERR]);

    // R6: pop while empty without a push leaves it empty and flags it
    a_r6_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) && host_rx_pop && !eng_rx_push && !ctrl_word[CTL_RX_CLR]
        |=> (rx_cnt == '0) && fifo_status[ST_RX_RERR]);

    // R7: the write error stays set until the clear bit rises
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[ST_TX_WERR] && !ctrl_word[CTL_TX_CLR] |=> fifo_status[ST_TX_WERR]);

    // R10: the error interrupt rises only together with a new flag
    a_r10_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fifo_err) |-> (host_cmd_push | eng_cmd_pop | eng_rx_push | host_rx_pop)
            || $past(host_cmd_push | eng_cmd_pop | eng_rx_push | host_rx_pop));
endmodule

bind qp_fifo_pair qp_fifo_pair_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .host_cmd_push(host_cmd_push), .eng_cmd_pop(eng_cmd_pop),
    .eng_rx_push(eng_rx_push), .host_rx_pop(host_rx_pop),
    .fifo_status(fifo_status), .irq_fifo_err(irq_fifo_err),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_empty(tx_empty), .rx_full(rx_full)
);

// File: tb/qp_fifo_pair_test.sv
module qp_fifo_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n;
    logic [13:0] ctrl_word;
    logic        host_cmd_push, eng_cmd_pop, eng_rx_push, host_rx_pop;
    logic [10:0] host_cmd_data, eng_cmd_data;
    logic [7:0]  eng_rx_data, host_rx_data;
    logic [11:0] fifo_status;
    logic        irq_rx_full, irq_tx_empty, irq_fifo_err;

    qp_fifo_pair uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .host_cmd_push(host_cmd_push), .host_cmd_data(host_cmd_data),
        .eng_cmd_pop(eng_cmd_pop), .eng_cmd_data(eng_cmd_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .fifo_status(fifo_status), .irq_rx_full(irq_rx_full),
        .irq_tx_empty(irq_tx_empty), .irq_fifo_err(irq_fifo_err)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // Reference model
    logic [10:0] m_tx[$];
    logic [7:0]  m_rx[$];
    bit m_txr, m_txw, m_rxr, m_rxw;

    function automatic logic [11:0] exp_status();
        logic [11:0] s = '0;
        s[0]  = m_rxr;
        s[1]  = m_rxw;
        s[3]  = (m_rx.size() == 0);
        s[6]  = m_txr;
        s[7]  = m_txw;
        s[11] = (m_tx.size() == DEPTH);
        return s;
    endfunction

    function automatic bit exp_rx_irq();
        return m_rx.size() >= int'(ctrl_word[7:2]);
    endfunction

    function automatic bit exp_tx_irq();
        return m_tx.size() <= int'(ctrl_word[13:8]);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs currently driven
    task automatic model_edge();
        if (ctrl_word[1]) begin
            m_tx.delete(); m_txr = 0; m_txw = 0;
        end else begin
            int n = m_tx.size();
            if (eng_cmd_pop && n == 0) m_txr = 1;
            if (host_cmd_push && n == DEPTH) m_txw = 1;
            if (eng_cmd_pop && n > 0) void'(m_tx.pop_front());
            if (host_cmd_push && n < DEPTH) m_tx.push_back(host_cmd_data);
        end
        if (ctrl_word[0]) begin
            m_rx.delete(); m_rxr = 0; m_rxw = 0;
        end else begin
            int n = m_rx.size();
            if (host_rx_pop && n == 0) m_rxr = 1;
            if (eng_rx_push && n == DEPTH) m_rxw = 1;
            if (host_rx_pop && n > 0) void'(m_rx.pop_front());
            if (eng_rx_push && n < DEPTH) m_rx.push_back(eng_rx_data);
        end
    endtask

    task automatic compare_all();
        logic [11:0] es = exp_status();
        check(fifo_status === es, "R4 status", 32'(fifo_status), 32'(es));
        check(irq_rx_full === exp_rx_irq(), "R8 irq_rx_full", 32'(irq_rx_full), 32'(exp_rx_irq()));
        check(irq_tx_empty === exp_tx_irq(), "R9 irq_tx_empty", 32'(irq_tx_empty), 32'(exp_tx_irq()));
        check(irq_fifo_err === (m_txr | m_txw | m_rxr | m_rxw), "R10 irq_fifo_err",
              32'(irq_fifo_err), 32'(m_txr | m_txw | m_rxr | m_rxw));
        if (m_tx.size() > 0)
            check(eng_cmd_data === m_tx[0], "R1 command head", 32'(eng_cmd_data), 32'(m_tx[0]));
        if (m_rx.size() > 0)
            check(host_rx_data === m_rx[0], "R1 receive head", 32'(host_rx_data), 32'(m_rx[0]));
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle_inputs();
        host_cmd_push = 0; eng_cmd_pop = 0; eng_rx_push = 0; host_rx_pop = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0;
        ctrl_word = {6'd1, 6'd60, 2'b00};
        idle_inputs();
        host_cmd_data = '0; eng_rx_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11: reset state
        check(fifo_status === 12'h008, "R11 reset status", 32'(fifo_status), 32'h008);
        check(irq_tx_empty === 1'b1 && irq_rx_full === 1'b0 && irq_fifo_err === 1'b0,
              "R11 reset irqs", {29'd0, irq_rx_full, irq_tx_empty, irq_fifo_err}, 32'b010);

        // R6: pop from empty command queue with simultaneous receive push
        eng_cmd_pop = 1; eng_rx_push = 1; eng_rx_data = 8'h5a;
        step();
        check(fifo_status[6] === 1'b1, "R6 command read error", 32'(fifo_status[6]), 1);
        check(fifo_status[3] === 1'b0, "R6 receive push taken", 32'(fifo_status[3]), 0);
        idle_inputs();
        repeat (4) step();
        check(fifo_status[6] === 1'b1, "R7 read error held", 32'(fifo_status[6]), 1);

        // R3: clear with pushes is ignored and removes errors
        ctrl_word[1] = 1; host_cmd_push = 1; host_cmd_data = 11'h123;
        repeat (2) step();
        ctrl_word[1] = 0; host_cmd_push = 0;
        step();
        check(fifo_status[6] === 1'b0 && fifo_status[7] === 1'b0, "R3 flags cleared",
              32'(fifo_status[7:6]), 0);
        eng_cmd_pop = 1;
        step();
        check(fifo_status[6] === 1'b1, "R3 queue was empty after clear", 32'(fifo_status[6]), 1);
        eng_cmd_pop = 0; ctrl_word[1] = 1; step(); ctrl_word[1] = 0;

        // R1/R5: fill command queue to 64, then overflow
        for (int i = 0; i < DEPTH; i++) begin
            host_cmd_push = 1; host_cmd_data = 11'(i * 7 + 3);
            step();
        end
        check(fifo_status[11] === 1'b1, "R4 full at 64", 32'(fifo_status[11]), 1);
        host_cmd_data = 11'h7aa;
        step();
        check(fifo_status[7] === 1'b1, "R5 write error on overflow", 32'(fifo_status[7]), 1);
        eng_cmd_pop = 1; host_cmd_data = 11'h655;
        step();
        check(fifo_status[11] === 1'b0, "R5 pop proceeds at full", 32'(fifo_status[11]), 0);
        host_cmd_push = 0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            check(eng_cmd_data === 11'((i + 1) * 7 + 3), "R5 contents unchanged",
                  32'(eng_cmd_data), 32'((i + 1) * 7 + 3));
            step();
        end
        eng_cmd_pop = 0;
        step();

        // R8: receive threshold boundary at 60
        ctrl_word[0] = 1; step(); ctrl_word[0] = 0;
        for (int i = 0; i < 59; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'(i); step();
        end
        eng_rx_push = 0; step();
        check(irq_rx_full === 1'b0, "R8 below threshold", 32'(irq_rx_full), 0);
        eng_rx_push = 1; eng_rx_data = 8'hc3; step();
        check(irq_rx_full === 1'b1, "R8 at threshold", 32'(irq_rx_full), 1);
        // R2: push and pop together keep the level
        host_rx_pop = 1; eng_rx_data = 8'h99; step();
        check(irq_rx_full === 1'b1, "R2 level kept", 32'(irq_rx_full), 1);
        check(host_rx_data === 8'd1, "R2 oldest popped", 32'(host_rx_data), 1);
        idle_inputs();
        ctrl_word[0] = 1; step(); ctrl_word[0] = 0;

        // Random phases
        for (int ph = 0; ph < 8; ph++) begin
            int pp = $urandom_range(10, 95);
            int qp = $urandom_range(10, 95);
            for (int c = 0; c < 400; c++) begin
                host_cmd_push = ($urandom_range(0, 99) < pp);
                eng_rx_push   = ($urandom_range(0, 99) < pp);
                eng_cmd_pop   = ($urandom_range(0, 99) < qp);
                host_rx_pop   = ($urandom_range(0, 99) < qp);
                host_cmd_data = 11'($urandom);
                eng_rx_data   = 8'($urandom);
                ctrl_word[0] = ($urandom_range(0, 99) == 0);
                ctrl_word[1] = ($urandom_range(0, 99) == 0);
                if ($urandom_range(0, 63) == 0) ctrl_word[13:2] = 12'($urandom);
                step();
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule